// File: doc/BRIEF.md
# Fault Supervisor With Auto-Restart

This block sits between the analog comparators of a flyback primary controller and its gate controller. It receives four raw comparator flags: line undervoltage, line overvoltage, secondary overvoltage and overcurrent. It also receives a level that marks the startup phase. From these it produces a gate-enable, a two-bit fault code and a one-cycle restart pulse. The restart pulse tells the gate controller to begin soft-start again.

Each flag first passes through its own deglitch filter. A filtered flag changes only after its raw input has held the new value for a set number of consecutive clock cycles.

A line fault (under- or overvoltage) blocks the gate until the line is back in range, and then the block restarts on its own. A secondary overvoltage is only acted on when it is armed. It is armed while the startup level is high, or during a fixed recovery window that begins at each auto-restart. An armed secondary overvoltage blocks the gate until the flag clears, and then the block restarts. Overcurrent only gates the switch off while its filtered flag is high. It is never recorded as a fault.

Top module: `fault_supervisor`

## Requirements
- R1: After a synchronous active-low reset, gate_en_o is 1, fault_code_o is 00 and restart_o is 0.
- R2: A raw flag that is high for fewer than its deglitch count of consecutive cycles has no effect on any output. A flag held for exactly that count does take effect.
- R3: When line_uv_i or line_ov_i is held high for LINE_DGL cycles, gate_en_o goes to 0 and fault_code_o goes to 01 on the clock edge that follows the LINE_DGL-th sampled high. Both outputs stay there while the line fault lasts. Whenever fault_code_o is not 00, gate_en_o is 0.
- R4: When the line fault input has been low for LINE_DGL cycles, the next edge sets restart_o to 1 for exactly one cycle. On that same edge fault_code_o returns to 00 and gate_en_o returns to 1.
- R5: While startup_i is 1, sec_ov_i held for SOV_DGL cycles sets fault_code_o to 10 and gate_en_o to 0 one edge later.
- R6: While startup_i is 0 and no recovery window is open, sec_ov_i is ignored: fault_code_o stays 00 and gate_en_o stays 1.
- R7: When sec_ov_i has been low for SOV_DGL cycles, a secondary fault ends with a one-cycle restart_o, and fault_code_o returns to 00 on the same edge.
- R8: Each restart opens a recovery window. In the RECOVER_CYC edges after the restart edge, a filtered secondary overvoltage that is present is acted on even when startup_i is 0. Once the window has run out, the flag is ignored again.
- R9: Overcurrent pulls gate_en_o low while its filtered flag is high, starting OC_DGL edges after it rises. gate_en_o recovers OC_DGL edges after the flag falls. fault_code_o stays 00 and no restart_o is produced.
- R10: A line fault has priority. When a filtered line fault is present, the next state is the line fault (code 01), even if a secondary overvoltage is present or already latched.
- R11: fault_code_o never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_uv_i | input | 1 | Raw line-undervoltage comparator flag |
| line_ov_i | input | 1 | Raw line-overvoltage comparator flag |
| sec_ov_i | input | 1 | Raw secondary-overvoltage comparator flag |
| over_cur_i | input | 1 | Raw overcurrent comparator flag |
| startup_i | input | 1 | High during the startup phase; arms the secondary check |
| gate_en_o | output | 1 | Permits gate pulses when 1 |
| fault_code_o | output | 2 | 00 none, 01 line fault, 10 secondary overvoltage, 11 unused |
| restart_o | output | 1 | One-cycle auto-restart request (re-enter soft-start) |

## Verification
Two situations make functions fall in the same cycle.

The first is a simultaneous line fault and secondary overvoltage. The bench gives the line and secondary filters equal deglitch counts and raises both raw flags on the same edge, so both filtered flags rise together. The code must go straight to 01 and never pass through 10.

The second is a line fault that clears while the secondary flag is still high. Here the restart pulse and the re-arming of the secondary check coincide. The bench expects 00 with restart_o high on the restart edge, then 10 on the very next edge.

// File: rtl/fs_pkg.sv
// Package: shared types for the fault supervisor.
// Assumes: fault code values are decoded by the gate controller.
package fs_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_LINE = 2'd1,
        ST_SOV  = 2'd2
    } fs_state_e;

    localparam logic [1:0] FC_NONE = 2'b00;
    localparam logic [1:0] FC_LINE = 2'b01;
    localparam logic [1:0] FC_SOV  = 2'b10;

    localparam int NUM_FLAGS = 4;
    localparam int IDX_UV  = 0;
    localparam int IDX_OV  = 1;
    localparam int IDX_SOV = 2;
    localparam int IDX_OC  = 3;

endpackage

// File: rtl/fs_deglitch.sv
// Module: fs_deglitch
// Filters one raw comparator flag. The output takes a new value only after
// the input has differed from it for DGL consecutive clock cycles.
// Assumes: the raw input is already synchronised to clk; DGL >= 1.
module fs_deglitch #(
    parameter int DGL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(DGL + 1);

    logic [CW-1:0] cnt_q;

    // Count consecutive disagreeing samples and flip the output on the DGL-th.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_o <= 1'b0;
        end else if (raw_i == filt_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(DGL - 1)) begin
            cnt_q  <= '0;
            filt_o <= raw_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fs_recovery_timer.sv
// Module: fs_recovery_timer
// Holds the secondary-overvoltage check open for WIN_CYC edges after each
// restart. It is reloaded on every restart.
// Assumes: load_i is high on the edge that issues the restart.
module fs_recovery_timer #(
    parameter int WIN_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic active_o
);
    localparam int TW = $clog2(WIN_CYC + 1);

    logic [TW-1:0] left_q;

    // Reload on restart, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= TW'(WIN_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active_o = (left_q != '0);
endmodule

// File: rtl/fs_fault_fsm.sv
// Module: fs_fault_fsm
// Fault state machine. Line faults take priority over secondary overvoltage,
// and leaving either fault state issues a restart. Overcurrent only masks
// the gate for as long as it is present.
// Assumes: all flag inputs are already deglitched.
module fs_fault_fsm
    import fs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_bad_i,
    input  logic       sov_i,
    input  logic       sov_armed_i,
    input  logic       oc_i,
    output logic       restart_req_o,
    output logic       restart_o,
    output logic       gate_en_o,
    output logic [1:0] code_o
);
    fs_state_e state_q, state_d;

    // Next-state decision with line priority.
    always_comb begin
        state_d       = state_q;
        restart_req_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (line_bad_i)                state_d = ST_LINE;
                else if (sov_i && sov_armed_i) state_d = ST_SOV;
            end
            ST_LINE: begin
                if (!line_bad_i) begin
                    state_d       = ST_RUN;
                    restart_req_o = 1'b1;
                end
            end
            ST_SOV: begin
                if (line_bad_i) begin
                    state_d = ST_LINE;
                end else if (!sov_i) begin
                    state_d       = ST_RUN;
                    restart_req_o = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State and restart-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            restart_o <= 1'b0;
        end else begin
            state_q   <= state_d;
            restart_o <= restart_req_o;
        end
    end

    // Output decode from the state register.
    always_comb begin
        unique case (state_q)
            ST_LINE: code_o = FC_LINE;
            ST_SOV:  code_o = FC_SOV;
            default: code_o = FC_NONE;
        endcase
        gate_en_o = (state_q == ST_RUN) && !oc_i;
    end
endmodule

// File: rtl/fault_supervisor.sv
// Module: fault_supervisor (top)
// Deglitches the four comparator flags, arms the secondary check during
// startup or the recovery window, and drives the gate enable, fault code
// and auto-restart pulse.
// Assumes: raw flags are synchronous to clk.
module fault_supervisor
    import fs_pkg::*;
#(
    parameter int LINE_DGL    = 16,
    parameter int SOV_DGL     = 16,
    parameter int OC_DGL      = 4,
    parameter int RECOVER_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_uv_i,
    input  logic       line_ov_i,
    input  logic       sec_ov_i,
    input  logic       over_cur_i,
    input  logic       startup_i,
    output logic       gate_en_o,
    output logic [1:0] fault_code_o,
    output logic       restart_o
);
    // Deglitch count for each flag index.
    function automatic int dgl_of(input int idx);
        if (idx == IDX_SOV) return SOV_DGL;
        if (idx == IDX_OC)  return OC_DGL;
        return LINE_DGL;
    endfunction

    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] flt_q;
    logic                 line_bad;
    logic                 sov_armed;
    logic                 win_active;
    logic                 restart_req;

    assign raw_flags = {over_cur_i, sec_ov_i, line_ov_i, line_uv_i};

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
            fs_deglitch #(.DGL(dgl_of(g))) u_dgl (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_i  (raw_flags[g]),
                .filt_o (flt_q[g])
            );
        end
    endgenerate

    assign line_bad  = flt_q[IDX_UV] | flt_q[IDX_OV];
    assign sov_armed = startup_i | win_active;

    fs_recovery_timer #(.WIN_CYC(RECOVER_CYC)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (restart_req),
        .active_o (win_active)
    );

    fs_fault_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_bad_i    (line_bad),
        .sov_i         (flt_q[IDX_SOV]),
        .sov_armed_i   (sov_armed),
        .oc_i          (flt_q[IDX_OC]),
        .restart_req_o (restart_req),
        .restart_o     (restart_o),
        .gate_en_o     (gate_en_o),
        .code_o        (fault_code_o)
    );
endmodule

// File: rtl/fault_supervisor_chk.sv
// Module: fault_supervisor_chk
// Property checker attached to every fault_supervisor instance through bind.
module fault_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gate_en_o,
    input logic [1:0] fault_code_o,
    input logic       restart_o,
    input logic       line_bad,
    input logic       sov_f,
    input logic       oc_f,
    input logic       sov_armed,
    input logic       win_active
);
    assert_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_code_o != 2'b11);

    assert_gate_off_in_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code_o != 2'b00) |-> !gate_en_o);

    assert_restart_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o);

    assert_restart_ends_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> (fault_code_o == 2'b00) && ($past(fault_code_o) != 2'b00));

    assert_line_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_bad |=> (fault_code_o == 2'b01));

    assert_sov_unarmed_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sov_f && !sov_armed && !line_bad && fault_code_o == 2'b00) |=> (fault_code_o == 2'b00));

    assert_restart_opens_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> win_active);

    assert_oc_masks_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oc_f |-> !gate_en_o);
endmodule

bind fault_supervisor fault_supervisor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_en_o    (gate_en_o),
    .fault_code_o (fault_code_o),
    .restart_o    (restart_o),
    .line_bad     (line_bad),
    .sov_f        (flt_q[2]),
    .oc_f         (flt_q[3]),
    .sov_armed    (sov_armed),
    .win_active   (win_active)
);

// File: tb/fault_supervisor_bench.sv
// Bench for fault_supervisor: sweeps pulse lengths for every flag, then
// steps through exact-timing, arming-window and priority cases.
module fault_supervisor_bench;
    localparam int LDG = 3;
    localparam int SDG = 3;
    localparam int ODG = 2;
    localparam int REC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uv = 1'b0, ov = 1'b0, sov = 1'b0, oc = 1'b0, st = 1'b1;
    logic       gate_en;
    logic [1:0] code;
    logic       rst_pulse;

    int n_run = 0;
    int n_fail = 0;
    bit wd_hit = 1'b0;

    // Trial monitor results.
    bit low_seen;
    bit code_seen;
    int restarts;

    always #4 clk = ~clk;

    fault_supervisor #(
        .LINE_DGL(LDG), .SOV_DGL(SDG), .OC_DGL(ODG), .RECOVER_CYC(REC)
    ) u_fault_supervisor (
        .clk(clk), .rst_n(rst_n),
        .line_uv_i(uv), .line_ov_i(ov), .sec_ov_i(sov), .over_cur_i(oc),
        .startup_i(st),
        .gate_en_o(gate_en), .fault_code_o(code), .restart_o(rst_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_flag(input int idx, input logic v);
        case (idx)
            0: uv = v;
            1: ov = v;
            2: sov = v;
            default: oc = v;
        endcase
    endtask

    task automatic step_mon(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!gate_en) low_seen = 1'b1;
            if (code != 2'b00) code_seen = 1'b1;
            if (rst_pulse) restarts++;
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One pulse of length len on flag idx, judged against the deglitch count.
    task automatic sweep_trial(input int idx, input int len, input int dg);
        bit eff;
        eff = (len >= dg);
        low_seen = 1'b0; code_seen = 1'b0; restarts = 0;
        set_flag(idx, 1'b1);
        step_mon(len);
        set_flag(idx, 1'b0);
        step_mon(dg + 8);
        chk(low_seen == eff, "R2 gate reaction", int'(low_seen), int'(eff));
        if (idx == 3) begin
            chk(!code_seen, "R9 oc leaves code", int'(code_seen), 0);
            chk(restarts == 0, "R9 oc no restart", restarts, 0);
        end else begin
            chk(code_seen == eff, "R2 code reaction", int'(code_seen), int'(eff));
            chk(restarts == (eff ? 1 : 0), "R4/R7 restart count", restarts, eff ? 1 : 0);
        end
        wait_n(4);
    endtask

    task automatic run_tests;
        // R1 reset state
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk(gate_en == 1'b1, "R1 gate after reset", int'(gate_en), 1);
        chk(code == 2'b00, "R1 code after reset", int'(code), 0);
        chk(rst_pulse == 1'b0, "R1 restart after reset", int'(rst_pulse), 0);

        // R2 sweep of pulse lengths on every flag (startup phase)
        for (int f = 0; f < 4; f++) begin
            int dg;
            dg = (f == 2) ? SDG : (f == 3) ? ODG : LDG;
            for (int len = 1; len <= dg + 1; len++) sweep_trial(f, len, dg);
        end

        // R3 exact assertion timing of a line overvoltage
        ov = 1'b1;
        wait_n(LDG);
        chk(gate_en == 1'b1, "R3 gate before deglitch", int'(gate_en), 1);
        wait_n(1);
        chk(gate_en == 1'b0, "R3 gate off", int'(gate_en), 0);
        chk(code == 2'b01, "R3 line code", int'(code), 1);
        wait_n(10);
        chk(code == 2'b01, "R3 line code held", int'(code), 1);
        // R4 exact recovery timing
        ov = 1'b0;
        wait_n(LDG);
        chk(code == 2'b01, "R4 still faulted", int'(code), 1);
        wait_n(1);
        chk(rst_pulse == 1'b1, "R4 restart pulse", int'(rst_pulse), 1);
        chk(code == 2'b00 && gate_en, "R4 code cleared gate on", int'(code), 0);
        wait_n(1);
        chk(rst_pulse == 1'b0, "R4 pulse one cycle", int'(rst_pulse), 0);

        // R5 and R7 secondary fault in startup
        wait_n(5);
        sov = 1'b1;
        wait_n(SDG + 1);
        chk(code == 2'b10 && !gate_en, "R5 secondary code", int'(code), 2);
        sov = 1'b0;
        wait_n(SDG + 1);
        chk(rst_pulse == 1'b1 && code == 2'b00, "R7 restart after secondary", int'(rst_pulse), 1);

        // R9 overcurrent exact timing
        wait_n(5);
        oc = 1'b1;
        wait_n(ODG - 1);
        chk(gate_en == 1'b1, "R9 gate before deglitch", int'(gate_en), 1);
        wait_n(1);
        chk(gate_en == 1'b0 && code == 2'b00, "R9 oc gate off", int'(gate_en), 0);
        oc = 1'b0;
        wait_n(ODG - 1);
        chk(gate_en == 1'b0, "R9 gate still off", int'(gate_en), 0);
        wait_n(1);
        chk(gate_en == 1'b1 && rst_pulse == 1'b0, "R9 gate back", int'(gate_en), 1);

        // R6 secondary flag ignored outside startup and window
        st = 1'b0;
        wait_n(REC + 10);
        sov = 1'b1;
        wait_n(SDG + 6);
        chk(code == 2'b00 && gate_en, "R6 secondary ignored", int'(code), 0);
        sov = 1'b0;
        wait_n(SDG + 3);

        // R8 window after a line restart arms the secondary check
        uv = 1'b1;
        wait_n(LDG + 1);
        uv = 1'b0;
        wait_n(LDG + 1);
        chk(rst_pulse == 1'b1, "R8 restart seen", int'(rst_pulse), 1);
        sov = 1'b1;
        wait_n(SDG + 1);
        chk(code == 2'b10, "R8 secondary armed in window", int'(code), 2);
        sov = 1'b0;
        wait_n(SDG + 1);
        chk(rst_pulse == 1'b1, "R8 restart from secondary", int'(rst_pulse), 1);
        wait_n(REC + 5);
        sov = 1'b1;
        wait_n(SDG + 6);
        chk(code == 2'b00 && gate_en, "R8 window expired", int'(code), 0);
        sov = 1'b0;
        wait_n(SDG + 3);

        // R10 simultaneous line and secondary (equal deglitch counts)
        st = 1'b1;
        low_seen = 1'b0; code_seen = 1'b0; restarts = 0;
        uv = 1'b1; sov = 1'b1;
        for (int i = 0; i < LDG + 6; i++) begin
            @(negedge clk);
            chk(code != 2'b10, "R10 no secondary code while line bad", int'(code), 1);
        end
        chk(code == 2'b01, "R10 line wins", int'(code), 1);
        uv = 1'b0;
        wait_n(LDG + 1);
        chk(rst_pulse == 1'b1 && code == 2'b00, "R10 restart on line clear", int'(code), 0);
        wait_n(1);
        chk(code == 2'b10 && !gate_en, "R10 secondary next edge", int'(code), 2);
        sov = 1'b0;
        wait_n(SDG + 1);
        chk(code == 2'b00, "R11 code back to none", int'(code), 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule